// File: doc/BRIEF.md
# Modem Control Pin Unit

This block owns two dual-purpose line pins of a serial link and the launch timing of the transmit data output. A six-field control word, written and read through a 16-bit word port, selects how the pins behave. In handshake mode the first pin is an active-low request-to-send output and the second pin is an active-low clear-to-send input. The block then gates the start of each frame from an attached framing transmitter. The transmitter reports a queued frame, an active transmission, a one-cycle strobe when the closing flag has gone out, and its programmed minimum gap between frames.

In general-purpose mode each pin is a bidirectional line whose direction is set by its own field. An output line drives its stored data bit. The data bit of an input line reads back the synchronized live level. The transmit data output is retimed on either edge of the transmit bit clock, as chosen by a control field. In handshake mode the output is held at mark (high) while no frame is being sent.

Top module: `mcp_top`

## Requirements
- R1: After reset all control fields are zero, both pin enables are low, the read word is zero except bits 1:0 (synchronized pin levels), and `td_out` is 1.
- R2: Bits 15:6 of the read word are always zero, whatever was written there.
- R3: Bits 5:2 read back as last written: bit 5 launch-edge select, bit 4 handshake enable, bit 3 pin A direction, bit 2 pin B direction (1 = output).
- R4: With bit 4 clear, `pin_a_oe` equals bit 3 and `pin_b_oe` equals bit 2; `pin_a_o` drives stored data bit 1 and `pin_b_o` drives stored data bit 0.
- R5: Read bit 1 (bit 0) returns the stored data bit when pin A (B) is an output in general-purpose mode, and otherwise the pin level through a two-flop synchronizer, visible two clocks after the pin changes.
- R6: A write to data bit 1 (bit 0) is ignored unless the direction field of that pin is already 1 before the write.
- R7: With bit 4 set, pin A is an output (`pin_a_oe`=1) carrying the inverted send request and pin B is an input (`pin_b_oe`=0).
- R8: In handshake mode the send request is raised (`pin_a_o`=0) one clock after a frame is pending or a transmission is active, and it stays raised through the transmission.
- R9: On the closing-flag strobe the send request, one clock later, stays raised only if another frame is pending and the minimum spacing is at most 2; otherwise it is released (`pin_a_o`=1).
- R10: `tx_go` = frame pending AND NOT transmitting AND (handshake disabled OR synchronized pin B low). It is never high while a frame is active, so pin B rising mid-frame cannot cut the frame short.
- R11: `td_out` loads the next data value one clock after a synchronized edge of `tclk` is seen: a rising edge when bit 5 is set, a falling edge when it is clear. This is three clocks after the `tclk` input changes.
- R12: In handshake mode, a launch while no frame is active loads 1 into `td_out` instead of `tx_bit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr | input | 1 | Control word write strobe |
| csr_wdata | input | 16 | Control word write data |
| csr_rdata | output | 16 | Control word read data |
| frame_pending | input | 1 | Transmitter has a frame queued |
| tx_active | input | 1 | Transmitter is sending a frame |
| close_flag_done | input | 1 | One-cycle strobe: closing flag sent |
| min_spacing | input | 4 | Programmed minimum gap between frames |
| tx_go | output | 1 | Permission to start the pending frame |
| tx_bit | input | 1 | Next serial data bit from the serializer |
| tclk | input | 1 | Transmit bit clock (sampled) |
| td_out | output | 1 | Retimed transmit data |
| pin_a_i | input | 1 | Pin A pad input level |
| pin_a_o | output | 1 | Pin A drive value |
| pin_a_oe | output | 1 | Pin A output enable |
| pin_b_i | input | 1 | Pin B pad input level |
| pin_b_o | output | 1 | Pin B drive value |
| pin_b_oe | output | 1 | Pin B output enable |

## Verification
The handshake is driven through three frame endings: one with a second frame queued and a gap of 2, one with a gap of 3, and one with nothing queued. These separate the spacing comparison from the queue test. Clear-to-send is held high, then dropped, and then raised mid-frame, which shows that it gates only the start of a frame. The general-purpose lines are driven through writes issued before and after the direction changes, with external levels toggling. This separates ignored writes from stored ones, and stored values from synchronized ones. A continuously toggling bit clock under both edge selections, with pseudo-random data, shows which edge launches the data and that the output is held at mark between frames.

// File: rtl/mcp_pkg.sv
package mcp_pkg;
    localparam int CSR_W   = 16;
    localparam int FIELD_W = 6;

    typedef struct packed {
        logic launch_rise;
        logic hs_en;
        logic a_dir;
        logic b_dir;
        logic a_dat;
        logic b_dat;
    } ctl_fields_t;

    typedef enum logic {
        PIN_MODE_GPIO   = 1'b0,
        PIN_MODE_HSHAKE = 1'b1
    } pin_mode_e;

    function automatic pin_mode_e mode_of(ctl_fields_t f);
        return f.hs_en ? PIN_MODE_HSHAKE : PIN_MODE_GPIO;
    endfunction

    function automatic logic [CSR_W-1:0] pack_readback(ctl_fields_t f,
                                                      logic a_rd,
                                                      logic b_rd);
        return {{(CSR_W-FIELD_W){1'b0}}, f.launch_rise, f.hs_en,
                f.a_dir, f.b_dir, a_rd, b_rd};
    endfunction
endpackage

// File: rtl/mcp_sync.sv
module mcp_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    always_ff @(posedge clk) begin
        if (rst) st[0] <= '0;
        else     st[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) st[i] <= '0;
            else     st[i] <= st[i-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/mcp_ctl_reg.sv
module mcp_ctl_reg
    import mcp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CSR_W-1:0] wdata,
    input  logic             a_sync,
    input  logic             b_sync,
    output ctl_fields_t      fields,
    output logic [CSR_W-1:0] rdata
);
    ctl_fields_t f_q;
    logic        a_rd, b_rd;
    logic        rsvd_unused;

    assign rsvd_unused = ^wdata[CSR_W-1:FIELD_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            f_q <= '0;
        end else if (wr) begin
            f_q.launch_rise <= wdata[5];
            f_q.hs_en       <= wdata[4];
            f_q.a_dir       <= wdata[3];
            f_q.b_dir       <= wdata[2];
            if (f_q.a_dir) f_q.a_dat <= wdata[1];
            if (f_q.b_dir) f_q.b_dat <= wdata[0];
        end
    end

    always_comb begin
        a_rd = (mode_of(f_q) == PIN_MODE_GPIO && f_q.a_dir) ? f_q.a_dat : a_sync;
        b_rd = (mode_of(f_q) == PIN_MODE_GPIO && f_q.b_dir) ? f_q.b_dat : b_sync;
    end

    assign rdata  = pack_readback(f_q, a_rd, b_rd);
    assign fields = f_q;

    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
        rdata[CSR_W-1:FIELD_W] == '0);
    p_a_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (wr && !f_q.a_dir) |=> $stable(f_q.a_dat));
    p_b_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (wr && !f_q.b_dir) |=> $stable(f_q.b_dat));
endmodule

// File: rtl/mcp_handshake.sv
module mcp_handshake #(
    parameter int SPACE_W     = 4,
    parameter int SPACE_LIMIT = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hs_en,
    input  logic               frame_pending,
    input  logic               tx_active,
    input  logic               close_flag,
    input  logic [SPACE_W-1:0] min_space,
    input  logic               cts_sync,
    output logic               rts_req,
    output logic               tx_go
);
    localparam logic [SPACE_W-1:0] LIMIT = SPACE_W'(SPACE_LIMIT);

    logic rts_q, rts_d, keep_after_close;

    always_comb begin
        keep_after_close = frame_pending && (min_space <= LIMIT);
        rts_d = rts_q;
        if (!hs_en)                          rts_d = 1'b0;
        else if (close_flag)                 rts_d = keep_after_close;
        else if (frame_pending || tx_active) rts_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) rts_q <= 1'b0;
        else     rts_q <= rts_d;
    end

    assign rts_req = rts_q;
    assign tx_go   = frame_pending && !tx_active && (!hs_en || !cts_sync);

    p_close_release_r9: assert property (@(posedge clk) disable iff (rst)
        (close_flag && min_space > LIMIT) |=> !rts_q);
    p_hold_low_r8: assert property (@(posedge clk) disable iff (rst)
        (hs_en && tx_active && !close_flag) |=> rts_q);
    p_cts_block_r10: assert property (@(posedge clk) disable iff (rst)
        (hs_en && cts_sync) |-> !tx_go);
    p_no_go_busy_r10: assert property (@(posedge clk) disable iff (rst)
        tx_active |-> !tx_go);
endmodule

// File: rtl/mcp_td_launch.sv
module mcp_td_launch (
    input  logic clk,
    input  logic rst,
    input  logic tclk_sync,
    input  logic rise_sel,
    input  logic hold_mark,
    input  logic tx_bit,
    output logic td
);
    logic tclk_prev, fire, td_q;

    always_comb begin
        if (rise_sel) fire = tclk_sync && !tclk_prev;
        else          fire = !tclk_sync && tclk_prev;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tclk_prev <= 1'b0;
            td_q      <= 1'b1;
        end else begin
            tclk_prev <= tclk_sync;
            if (fire) td_q <= hold_mark ? 1'b1 : tx_bit;
        end
    end

    assign td = td_q;

    p_hold_mark_r12: assert property (@(posedge clk) disable iff (rst)
        (fire && hold_mark) |=> td_q);
    p_no_fire_r11: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(td_q));
endmodule

// File: rtl/mcp_top.sv
module mcp_top
    import mcp_pkg::*;
#(
    parameter int SPACE_W     = 4,
    parameter int SPACE_LIMIT = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               csr_wr,
    input  logic [CSR_W-1:0]   csr_wdata,
    output logic [CSR_W-1:0]   csr_rdata,
    input  logic               frame_pending,
    input  logic               tx_active,
    input  logic               close_flag_done,
    input  logic [SPACE_W-1:0] min_spacing,
    output logic               tx_go,
    input  logic               tx_bit,
    input  logic               tclk,
    output logic               td_out,
    input  logic               pin_a_i,
    output logic               pin_a_o,
    output logic               pin_a_oe,
    input  logic               pin_b_i,
    output logic               pin_b_o,
    output logic               pin_b_oe
);
    localparam int SYNC_W = 3;

    logic [SYNC_W-1:0] raw, synced;
    ctl_fields_t       f;
    logic              rts_req;
    pin_mode_e         mode;

    assign raw = {tclk, pin_a_i, pin_b_i};

    mcp_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(raw), .q(synced)
    );

    mcp_ctl_reg u_reg (
        .clk(clk), .rst(rst), .wr(csr_wr), .wdata(csr_wdata),
        .a_sync(synced[1]), .b_sync(synced[0]),
        .fields(f), .rdata(csr_rdata)
    );

    assign mode = mode_of(f);

    mcp_handshake #(.SPACE_W(SPACE_W), .SPACE_LIMIT(SPACE_LIMIT)) u_hs (
        .clk(clk), .rst(rst), .hs_en(f.hs_en),
        .frame_pending(frame_pending), .tx_active(tx_active),
        .close_flag(close_flag_done), .min_space(min_spacing),
        .cts_sync(synced[0]), .rts_req(rts_req), .tx_go(tx_go)
    );

    mcp_td_launch u_td (
        .clk(clk), .rst(rst), .tclk_sync(synced[2]),
        .rise_sel(f.launch_rise),
        .hold_mark(f.hs_en && !tx_active),
        .tx_bit(tx_bit), .td(td_out)
    );

    always_comb begin
        if (mode == PIN_MODE_HSHAKE) begin
            pin_a_oe = 1'b1;
            pin_a_o  = !rts_req;
            pin_b_oe = 1'b0;
        end else begin
            pin_a_oe = f.a_dir;
            pin_a_o  = f.a_dat;
            pin_b_oe = f.b_dir;
        end
        pin_b_o = f.b_dat;
    end

    p_hs_dir_r7: assert property (@(posedge clk) disable iff (rst)
        f.hs_en |-> (pin_a_oe && !pin_b_oe));
    p_gpio_dir_r4: assert property (@(posedge clk) disable iff (rst)
        !f.hs_en |-> (pin_a_oe == csr_rdata[3] && pin_b_oe == csr_rdata[2]));
endmodule

// File: tb/tb_mcp_top.sv
module tb_mcp_top;
    localparam time CYC = 20ns;

    logic        clk = 0, rst = 1;
    logic        csr_wr = 0;
    logic [15:0] csr_wdata = 0;
    logic [15:0] csr_rdata;
    logic        frame_pending = 0, tx_active = 0, close_flag_done = 0;
    logic [3:0]  min_spacing = 0;
    logic        tx_go, tx_bit = 0, tclk = 0, td_out;
    logic        ext_a = 0, ext_b = 0;
    logic        pin_a_i, pin_a_o, pin_a_oe, pin_b_i, pin_b_o, pin_b_oe;

    int checks = 0, fails = 0;
    bit done = 0;

    always #(CYC/2) clk = ~clk;

    assign pin_a_i = pin_a_oe ? pin_a_o : ext_a;
    assign pin_b_i = pin_b_oe ? pin_b_o : ext_b;

    mcp_top dut (.*);

    // behavioural reference
    bit m_x, m_hs, m_ad, m_bd, m_a, m_b, m_rts, m_td;
    bit ha[$], hb[$], ht[$];
    bit m_tprev;

    function automatic bit m_oe_a(); return m_hs || m_ad; endfunction
    function automatic bit m_oe_b(); return !m_hs && m_bd; endfunction
    function automatic bit m_o_a();  return m_hs ? !m_rts : m_a; endfunction
    function automatic bit sa(); return ha[1]; endfunction
    function automatic bit sb(); return hb[1]; endfunction

    task automatic m_reset();
        {m_x, m_hs, m_ad, m_bd, m_a, m_b, m_rts, m_tprev} = '0;
        m_td = 1;
        ha = '{0, 0}; hb = '{0, 0}; ht = '{0, 0};
    endtask

    initial m_reset();

    always @(posedge clk) begin
        if (rst) m_reset();
        else begin
            bit pa, pb, fire, nrts;
            pa = m_oe_a() ? m_o_a() : ext_a;
            pb = m_oe_b() ? m_b : ext_b;
            fire = m_x ? (ht[1] && !m_tprev) : (!ht[1] && m_tprev);
            if (fire) m_td = (m_hs && !tx_active) ? 1 : tx_bit;
            m_tprev = ht[1];
            nrts = m_rts;
            if (!m_hs) nrts = 0;
            else if (close_flag_done) nrts = frame_pending && (min_spacing <= 2);
            else if (frame_pending || tx_active) nrts = 1;
            m_rts = nrts;
            if (csr_wr) begin
                if (m_ad) m_a = csr_wdata[1];
                if (m_bd) m_b = csr_wdata[0];
                m_x = csr_wdata[5]; m_hs = csr_wdata[4];
                m_ad = csr_wdata[3]; m_bd = csr_wdata[2];
            end
            ha.push_front(pa); void'(ha.pop_back());
            hb.push_front(pb); void'(hb.pop_back());
            ht.push_front(tclk); void'(ht.pop_back());
        end
    end

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s t=%0t actual=%h expected=%h", req, $time, act, exp);
        end
    endtask

    // per-cycle comparison, away from the edge
    always @(posedge clk) begin
        #5;
        if (!done) begin
            bit r1, r0;
            r1 = (!m_hs && m_ad) ? m_a : sa();
            r0 = (!m_hs && m_bd) ? m_b : sb();
            chk("R2", csr_rdata[15:6], 0);
            chk("R3", csr_rdata[5:2], {m_x, m_hs, m_ad, m_bd});
            chk("R5", csr_rdata[1:0], {r1, r0});
            chk(m_hs ? "R7" : "R4", {pin_a_oe, pin_b_oe}, {m_oe_a(), m_oe_b()});
            chk(m_hs ? "R8" : "R4", pin_a_o, m_o_a());
            chk("R4", pin_b_o, m_b);
            chk("R10", tx_go, frame_pending && !tx_active && (!m_hs || !sb()));
            chk(m_hs ? "R12" : "R11", td_out, m_td);
        end
    end

    task automatic wr(logic [15:0] d);
        @(negedge clk); csr_wr = 1; csr_wdata = d;
        @(negedge clk); csr_wr = 0; csr_wdata = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        bit [15:0] lfsr = 16'hACE1;
        fork
            forever begin
                repeat (3) @(negedge clk);
                tclk = ~tclk;
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                tx_bit = lfsr[0];
            end
        join_none
        idle(3);
        @(posedge clk); #5;
        chk("R1", {csr_rdata, pin_a_oe, pin_b_oe, td_out}, {16'h0, 1'b0, 1'b0, 1'b1});
        @(negedge clk); rst = 0;
        idle(4);

        // reserved bits and field readback; data write ignored while input (R6)
        wr(16'hFFC3);
        idle(1);
        chk("R6", pin_a_o, 0);
        wr(16'hFFEC);
        idle(20);
        chk("R3", csr_rdata[5:2], 4'b1011);
        chk("R6", csr_rdata[1], 0);
        wr(16'h002E);
        idle(2);
        chk("R4", {pin_a_oe, pin_a_o}, 2'b11);
        // inputs toggling, direction changes
        wr(16'h0003);
        for (int i = 0; i < 12; i++) begin
            ext_a = i[0]; ext_b = i[1];
            idle(3);
        end
        wr(16'h000C); wr(16'h000D); wr(16'h0004);
        idle(10);

        // handshake mode, bit 5 clear then set later
        wr(16'h0010);
        ext_b = 1; frame_pending = 1;
        idle(8);
        chk("R10", tx_go, 0);
        ext_b = 0;
        idle(3);
        chk("R10", tx_go, 1);
        tx_active = 1;
        idle(5);
        ext_b = 1;
        idle(6);
        chk("R8", pin_a_o, 0);
        // close with another frame and spacing 2: stays low
        min_spacing = 2; close_flag_done = 1;
        @(posedge clk); #5; chk("R9", pin_a_o, 0);
        @(negedge clk); close_flag_done = 0;
        idle(6);
        // spacing 3: released
        min_spacing = 3; close_flag_done = 1;
        @(posedge clk); #5; chk("R9", pin_a_o, 1);
        @(negedge clk); close_flag_done = 0; tx_active = 0; frame_pending = 0;
        idle(4);
        frame_pending = 1; tx_active = 1; ext_b = 0;
        idle(6);
        wr(16'h0030);
        idle(12);
        // nothing queued: released
        frame_pending = 0; min_spacing = 1; close_flag_done = 1;
        @(posedge clk); #5; chk("R9", pin_a_o, 1);
        @(negedge clk); close_flag_done = 0; tx_active = 0;
        idle(30);
        wr(16'h0000);
        idle(30);
        done = 1;
        idle(1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule